// File: doc/BRIEF.md
# Pipelined Burst SRAM

A single-port synchronous memory with registered address, control and write data, and a registered read path. One start address opens a four-beat burst. The first beat uses the address on the bus. The next three come from a two-bit internal beat counter, which a burst-advance input steps. The beats follow either a linear or an interleaved order, chosen by an order-select input. Two load strobes can start a burst: a processor-side strobe, which only counts while the chip enable is active, and a controller-side strobe, which always counts.

Writes are decided within the access cycle. A global write strobe writes the whole word. Otherwise, a byte-write strobe together with per-byte selects writes only the chosen lanes. Read data appears one clock after the access cycle. An output-enable input blanks the output at once, and is modelled as a valid flag with the data forced to zero. A sleep input freezes every register and keeps the stored contents.

Top module: `burst_sram`

## Requirements
- R1: A load cycle (`ld_ctl_ni` low, or `ld_cpu_ni` low with `en_ni` low) with the part selected (`en_ni`=0, `sel_i`=1, `sel_ni`=0) accesses `addr_i` as beat 0. If that access is a read, `rvalid_o` is 1 after the next rising edge and `rdata_o` holds the stored word.
- R2: In a non-load cycle of an open burst, `adv_ni`=0 steps the beat count by one and accesses the next beat. `adv_ni`=1 accesses the same beat again.
- R3: With `lin_order_i`=1, beat n uses the low address bits (start+n) mod 4. The address bits above bit 1 never change within a burst.
- R4: With `lin_order_i`=0, beat n uses the low address bits start XOR n.
- R5: `wr_all_ni`=0 writes every byte of the accessed word, whatever the levels of `wr_byte_ni` and `byte_sel_ni`.
- R6: With `wr_all_ni`=1 and `wr_byte_ni`=0, only lane k with `byte_sel_ni[k]`=0 is written. Lane k is `wdata_i[8k+7:8k]`. A write cycle gives `rvalid_o`=0 after the next edge.
- R7: `out_en_ni`=1 forces `rvalid_o`=0 and `rdata_o`=0 in the same cycle, without waiting for an edge.
- R8: While `sleep_i`=1, no register or storage location changes. The output and the burst position stay as they were, and contents are retained.
- R9: A load cycle with `en_ni`=1, `sel_i`=0 or `sel_ni`=1 closes the burst. `rvalid_o` is 0 after the next edge, and later advance cycles access nothing.
- R10: `ld_cpu_ni` low while `en_ni` is high is not a load. The open burst carries on as in R2.
- R11: While `rst_ni` is low, and after it is released, `rvalid_o` is 0 and no burst is open.
- R12: A read of a word in the cycle right after a write to that word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze all state when high |
| en_ni | input | 1 | Chip enable, active low |
| sel_i | input | 1 | Chip select, active high |
| sel_ni | input | 1 | Chip select, active low |
| ld_cpu_ni | input | 1 | Processor-side load strobe, active low |
| ld_ctl_ni | input | 1 | Controller-side load strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| lin_order_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | Start address |
| wr_all_ni | input | 1 | Global write, active low |
| wr_byte_ni | input | 1 | Byte write enable, active low |
| byte_sel_ni | input | BYTES | Per-lane write select, active low |
| wdata_i | input | BYTES*BYTE_W | Write data |
| out_en_ni | input | 1 | Output enable, active low |
| rdata_o | output | BYTES*BYTE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench targets start addresses whose low bits are not zero, in both orders. A design that carried out of bit 1, or that used addition where the order calls for XOR, would return the wrong word on the wrapped beats. It steps through every byte mask and reads straight after each write. A merge that was wrong, or a read that was a cycle stale, would show old lanes. It holds the advance input high, sleeps in the middle of a burst, and gives the processor strobe while the chip enable is inactive. A counter that moved, a write that got through during sleep, or a false reload would each put the beat sequence out of step. Deselect loads are followed by advance cycles, to catch a burst that keeps reading after it has been closed.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // beat offset inside the four-word block
  function automatic logic [1:0] beat_offset(logic [1:0] start, logic [1:0] beat, logic lin);
    return lin ? 2'(start + beat) : (start ^ beat);
  endfunction
endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              en_ni,
  input  logic              sel_i,
  input  logic              sel_ni,
  input  logic              ld_cpu_ni,
  input  logic              ld_ctl_ni,
  input  logic              adv_ni,
  input  logic              lin_order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [1:0]        cnt_o,
  output logic              act_o
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;
  logic              act_q, act_n;
  logic              load, pick;

  always_comb begin
    load   = !ld_ctl_ni || (!ld_cpu_ni && !en_ni);
    pick   = !en_ni && sel_i && !sel_ni;
    base_n = base_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    if (load) begin
      base_n = addr_i;
      cnt_n  = '0;
      act_n  = pick;
    end else if (act_q && !adv_ni) begin
      cnt_n = cnt_q + 2'd1;
    end
  end

  assign acc_o      = act_n;
  assign acc_addr_o = {base_n[ADDR_W-1:2], beat_offset(base_n[1:0], cnt_n, lin_order_i)};
  assign cnt_o      = cnt_q;
  assign act_o      = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (run_i) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
    end
  end
endmodule

// File: rtl/burst_sram_wctl.sv
module burst_sram_wctl #(
  parameter int BYTES = 2
) (
  input  logic             wr_all_ni,
  input  logic             wr_byte_ni,
  input  logic [BYTES-1:0] byte_sel_ni,
  output logic             wr_o,
  output logic [BYTES-1:0] mask_o
);
  assign wr_o = !wr_all_ni || !wr_byte_ni;

  for (genvar k = 0; k < BYTES; k++) begin : g_mask
    assign mask_o[k] = !wr_all_ni || (!wr_byte_ni && !byte_sel_ni[k]);
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    acc_i,
  input  logic                    wr_i,
  input  logic [BYTES-1:0]        mask_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  logic rvalid_q;

  assign rd_en = run_i && acc_i && !wr_i;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (run_i && acc_i && wr_i && mask_i[k]) mem_q[addr_i] <= wdata_i[k*BYTE_W +: BYTE_W];
      if (rd_en) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[k*BYTE_W +: BYTE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rvalid_q <= 1'b0;
    else if (run_i) rvalid_q <= rd_en;
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sleep_i,
  input  logic                    en_ni,
  input  logic                    sel_i,
  input  logic                    sel_ni,
  input  logic                    ld_cpu_ni,
  input  logic                    ld_ctl_ni,
  input  logic                    adv_ni,
  input  logic                    lin_order_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_all_ni,
  input  logic                    wr_byte_ni,
  input  logic [BYTES-1:0]        byte_sel_ni,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic                    out_en_ni,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int WORD_W = BYTES * BYTE_W;

  logic              run;
  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        burst_cnt;
  logic              burst_act;
  logic              wr;
  logic [BYTES-1:0]  mask;
  logic [WORD_W-1:0] rd_data;
  logic              rd_valid;

  assign run = !sleep_i;

  burst_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .en_ni      (en_ni),
    .sel_i      (sel_i),
    .sel_ni     (sel_ni),
    .ld_cpu_ni  (ld_cpu_ni),
    .ld_ctl_ni  (ld_ctl_ni),
    .adv_ni     (adv_ni),
    .lin_order_i(lin_order_i),
    .addr_i     (addr_i),
    .acc_o      (acc),
    .acc_addr_o (acc_addr),
    .cnt_o      (burst_cnt),
    .act_o      (burst_act)
  );

  burst_sram_wctl #(.BYTES(BYTES)) u_wctl (
    .wr_all_ni  (wr_all_ni),
    .wr_byte_ni (wr_byte_ni),
    .byte_sel_ni(byte_sel_ni),
    .wr_o       (wr),
    .mask_o     (mask)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .acc_i   (acc),
    .wr_i    (wr),
    .mask_i  (mask),
    .addr_i  (acc_addr),
    .wdata_i (wdata_i),
    .rdata_o (rd_data),
    .rvalid_o(rd_valid)
  );

  // output gate acts without a clock
  assign rvalid_o = rd_valid && !out_en_ni;
  assign rdata_o  = rvalid_o ? rd_data : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              en_ni,
  input logic              sel_i,
  input logic              sel_ni,
  input logic              ld_cpu_ni,
  input logic              ld_ctl_ni,
  input logic              adv_ni,
  input logic              wr_all_ni,
  input logic              wr_byte_ni,
  input logic              out_en_ni,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [1:0]        burst_cnt,
  input logic              burst_act,
  input logic              rd_valid
);
  logic ld, pick, no_ld;
  assign ld    = !ld_ctl_ni || (!ld_cpu_ni && !en_ni);
  assign pick  = !en_ni && sel_i && !sel_ni;
  assign no_ld = !ld;

  a_r1_load_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && ld && pick) |=> (burst_act && burst_cnt == 2'd0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && no_ld && adv_ni) |=> $stable(burst_cnt));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && no_ld && !adv_ni && burst_act) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

  a_r6_write_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && (!wr_all_ni || !wr_byte_ni)) |=> !rd_valid);

  a_r7_oe_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> (!rvalid_o && rdata_o == '0));

  a_r8_sleep_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(burst_cnt) && $stable(burst_act) && $stable(rd_valid)));

  a_r9_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && ld && !pick) |=> (!burst_act && !rd_valid));

  a_r10_cpu_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && en_ni && !ld_cpu_ni && ld_ctl_ni && burst_act) |=> burst_act);
endmodule

bind burst_sram burst_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .en_ni     (en_ni),
  .sel_i     (sel_i),
  .sel_ni    (sel_ni),
  .ld_cpu_ni (ld_cpu_ni),
  .ld_ctl_ni (ld_ctl_ni),
  .adv_ni    (adv_ni),
  .wr_all_ni (wr_all_ni),
  .wr_byte_ni(wr_byte_ni),
  .out_en_ni (out_en_ni),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .burst_cnt (burst_cnt),
  .burst_act (burst_act),
  .rd_valid  (rd_valid)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int WW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          sleep_i, en_ni, sel_i, sel_ni, ld_cpu_ni, ld_ctl_ni, adv_ni, lin_order_i;
  logic [AW-1:0] addr_i;
  logic          wr_all_ni, wr_byte_ni, out_en_ni;
  logic [NB-1:0] byte_sel_ni;
  logic [WW-1:0] wdata_i;
  logic [WW-1:0] rdata_o;
  logic          rvalid_o;

  int checks = 0;
  int failures = 0;

  logic [WW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_act, m_valid;
  logic [WW-1:0] m_data;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_burst_sram (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .en_ni(en_ni), .sel_i(sel_i),
    .sel_ni(sel_ni), .ld_cpu_ni(ld_cpu_ni), .ld_ctl_ni(ld_ctl_ni), .adv_ni(adv_ni),
    .lin_order_i(lin_order_i), .addr_i(addr_i), .wr_all_ni(wr_all_ni),
    .wr_byte_ni(wr_byte_ni), .byte_sel_ni(byte_sel_ni), .wdata_i(wdata_i),
    .out_en_ni(out_en_ni), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [1:0] exp_off(logic [1:0] s, logic [1:0] n, logic lin);
    return lin ? 2'(s + n) : (s ^ n);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(string tag, logic v, logic [WW-1:0] d, logic ev, logic [WW-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      failures++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h", tag, v, d, ev, ed);
    end
  endtask

  task automatic quiet();
    sleep_i = 0; en_ni = 0; sel_i = 1; sel_ni = 0; ld_cpu_ni = 1; ld_ctl_ni = 1;
    adv_ni = 1; wr_all_ni = 1; wr_byte_ni = 1; byte_sel_ni = '1; out_en_ni = 0;
  endtask

  // model one access cycle, clock it, compare
  task automatic tick(string tag);
    logic ld, pk, acc;
    logic [AW-1:0] a;
    if (!sleep_i) begin
      ld = !ld_ctl_ni || (!ld_cpu_ni && !en_ni);
      pk = !en_ni && sel_i && !sel_ni;
      acc = 1'b0;
      if (ld) begin
        if (pk) begin m_base = addr_i; m_cnt = 2'd0; m_act = 1'b1; acc = 1'b1; end
        else m_act = 1'b0;
      end else if (m_act) begin
        if (!adv_ni) m_cnt = m_cnt + 2'd1;
        acc = 1'b1;
      end
      m_valid = 1'b0;
      if (acc) begin
        a = {m_base[AW-1:2], exp_off(m_base[1:0], m_cnt, lin_order_i)};
        if (!wr_all_ni || !wr_byte_ni) begin
          for (int k = 0; k < NB; k++)
            if (!wr_all_ni || !byte_sel_ni[k]) ref_mem[a][k*BW +: BW] = wdata_i[k*BW +: BW];
        end else begin
          m_valid = 1'b1;
          m_data  = ref_mem[a];
        end
      end
    end
    @(posedge clk);
    #1;
    check(tag, rvalid_o, rdata_o, m_valid && !out_en_ni, (m_valid && !out_en_ni) ? m_data : '0);
  endtask

  task automatic load(logic [AW-1:0] a, logic lin);
    quiet();
    ld_ctl_ni = 0; addr_i = a; lin_order_i = lin;
  endtask

  task automatic read_burst(logic [AW-1:0] a, logic lin, string tag);
    load(a, lin);
    tick(tag);
    for (int i = 0; i < 4; i++) begin
      quiet(); adv_ni = 0;
      tick(tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: got running expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    m_base = '0; m_cnt = '0; m_act = 0; m_valid = 0; m_data = '0;
    addr_i = '0; wdata_i = '0; lin_order_i = 1;
    quiet();
    rst_ni = 0;
    #1;
    check("R11 in reset", rvalid_o, rdata_o, 1'b0, '0);
    repeat (3) @(posedge clk);
    #1;
    rst_ni = 1;
    tick("R11 after reset");

    // R5: fill with global writes, byte controls set against it
    for (int i = 0; i < DEPTH; i++) begin
      load(AW'(i), 1);
      wr_all_ni = 0; wr_byte_ni = 0; byte_sel_ni = '1;
      wdata_i = WW'($urandom);
      tick("R5 fill");
    end
    read_burst(8'h10, 1, "R1 R5 readback");

    // R3 linear wrap, R4 interleaved
    read_burst(8'h15, 1, "R3 linear from 1");
    read_burst(8'h2f, 1, "R3 linear wrap from 3");
    read_burst(8'h16, 0, "R4 interleave from 2");
    read_burst(8'h33, 0, "R4 interleave from 3");

    // R2 hold then step
    load(8'h41, 1); tick("R1 start");
    quiet(); adv_ni = 1; tick("R2 hold");
    quiet(); adv_ni = 1; tick("R2 hold");
    quiet(); adv_ni = 0; tick("R2 step");
    quiet(); adv_ni = 0; tick("R2 step");

    // R6 every mask, R12 immediate readback
    for (int m = 0; m < (1 << NB); m++) begin
      load(8'h50 + AW'(m), 1);
      wr_byte_ni = 0; byte_sel_ni = NB'(m); wdata_i = WW'($urandom);
      tick("R6 byte write");
      load(8'h50 + AW'(m), 1);
      tick("R12 read after write");
    end
    // R5 global wins over byte selects
    load(8'h60, 1); wr_all_ni = 0; wr_byte_ni = 1; byte_sel_ni = '1; wdata_i = 16'hbeef;
    tick("R5 global write");
    load(8'h60, 1); tick("R12 R5 readback");

    // R7 output enable blanks
    load(8'h70, 0); tick("R1 start");
    quiet(); adv_ni = 0; out_en_ni = 1; #1;
    check("R7 async blank", rvalid_o, rdata_o, 1'b0, '0);
    tick("R7 blank");
    quiet(); adv_ni = 0; tick("R7 restore");

    // R8 sleep mid-burst, blocked write
    load(8'h84, 1); tick("R1 start");
    quiet(); adv_ni = 0; tick("R2 step");
    for (int i = 0; i < 3; i++) begin
      quiet(); sleep_i = 1; ld_ctl_ni = 0; addr_i = 8'h84; wr_all_ni = 0; wdata_i = 16'h1234;
      tick("R8 sleep hold");
    end
    quiet(); adv_ni = 0; tick("R8 resume");
    load(8'h84, 1); tick("R8 retained");

    // R9 deselect variants
    for (int v = 0; v < 3; v++) begin
      load(8'h90, 1); tick("R1 start");
      quiet(); ld_ctl_ni = 0; addr_i = 8'h91;
      if (v == 0) sel_i = 0; else if (v == 1) sel_ni = 1; else en_ni = 1;
      tick("R9 deselect");
      quiet(); adv_ni = 0; tick("R9 no access");
      quiet(); adv_ni = 0; tick("R9 no access");
    end

    // R10 cpu strobe ignored with chip enable inactive
    load(8'ha2, 0); tick("R1 start");
    quiet(); ld_cpu_ni = 0; en_ni = 1; adv_ni = 0; addr_i = 8'h00; tick("R10 ignored");
    quiet(); adv_ni = 0; tick("R10 continue");
    quiet(); ld_cpu_ni = 0; addr_i = 8'hb3; tick("R1 cpu load");
    quiet(); adv_ni = 0; tick("R3 cpu burst");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      quiet();
      ld_ctl_ni   = ($urandom_range(0, 9) > 1);
      ld_cpu_ni   = ($urandom_range(0, 9) > 1);
      en_ni       = ($urandom_range(0, 9) == 0);
      sel_i       = ($urandom_range(0, 19) != 0);
      sel_ni      = ($urandom_range(0, 19) == 0);
      adv_ni      = ($urandom_range(0, 9) > 6);
      wr_all_ni   = ($urandom_range(0, 9) != 0);
      wr_byte_ni  = ($urandom_range(0, 9) > 1);
      byte_sel_ni = NB'($urandom);
      out_en_ni   = ($urandom_range(0, 9) == 0);
      sleep_i     = ($urandom_range(0, 19) == 0);
      lin_order_i = 1'($urandom);
      addr_i      = AW'($urandom);
      wdata_i     = WW'($urandom);
      tick("RND R1 R2 R3 R4 R6");
    end

    summary();
    $finish;
  end
endmodule